// File: doc/BRIEF.md
# Transmit Packet Length Tagger

This block sits on the processor write path into a transmit byte queue that feeds a serial framer. Software programs a 16-bit packet length through two byte-wide count ports. The high byte is held in a staging register and the low-byte write commits both halves. The block keeps a down-counter of the bytes left in the packet. Each data byte accepted into the queue is stored with a ninth bit, the end-of-packet marker. That bit is set on the byte written while the counter stands at one.

The queue holds 128 entries of 9 bits and drains through a valid/ready output. `out_valid` is high whenever the queue is not empty. An entry leaves only on a cycle with both `out_valid` and `out_ready` high. While `out_ready` is low, `out_data` holds still. The write side has no back-pressure. A write into a full queue is dropped and sets a sticky overflow flag.

A 3-bit select picks a low-fill threshold. A sticky interrupt flag reports when the fill level has fallen to or below that threshold. An optional cycle mode reloads the programmed length after every tagged byte, so that a stream of equal-length packets needs no reprogramming.

Top module: `txlen_tagger`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid`, `ovf_flag` and `low_irq` are 0. Reset clears the counter, the staged high byte, the programmed length and the queue.
- R2: A write on `cnt_hi_we` changes only the staged high byte. The active counter and the tagging of later data bytes are unchanged until the next `cnt_lo_we` write.
- R3: A `cnt_lo_we` write loads {staged high byte, `cnt_wdata`} as the length N and the counter. With N ≥ 1, the N-th accepted data byte after the load leaves with `out_data[8]` = 1, and the bytes before it leave with 0. `out_data[7:0]` carries the written byte.
- R4: With `cycle_en` = 0, after the tagged byte the counter rests at zero, and no further byte is tagged until the next `cnt_lo_we` write.
- R5: With `cycle_en` = 1, every N-th accepted byte is tagged, packet after packet, without reprogramming.
- R6: A length of 0 tags no byte. A length of 1 in cycle mode tags every byte.
- R7: `out_valid` is 1 exactly when the queue holds data. While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` stay unchanged on the next cycle. Bytes leave in write order.
- R8: A `wr_en` write while the queue holds 128 entries is dropped and does not advance the counter. It sets `ovf_flag` in the next cycle. `ovf_flag` stays set until an `ovf_clr` pulse, which clears it in the next cycle.
- R9: `low_irq` sets one cycle after the fill level is at or below (`low_sel`+1)×8, giving 8, 16, …, 64. It stays set until a `low_clr` pulse, which forces it to 0 in the next cycle.
- R10: The length covers the full 16 bits. With a high byte of 0x01 and a low byte of 0x2C, byte 300 is tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_hi_we | input | 1 | Write strobe for the staged high length byte |
| cnt_lo_we | input | 1 | Write strobe for the low length byte; commits the 16-bit length |
| cnt_wdata | input | 8 | Length byte for either strobe |
| cycle_en | input | 1 | Reload the length after each tagged byte |
| wr_en | input | 1 | Data write strobe into the queue |
| wr_data | input | 8 | Data byte |
| low_sel | input | 3 | Low-fill threshold code; threshold is (code+1)×8 |
| low_clr | input | 1 | Clears `low_irq` |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| out_valid | output | 1 | Queue output holds a byte |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 9 | Bit 8 is the end-of-packet marker; bits 7:0 are data |
| low_irq | output | 1 | Sticky low-fill interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The tagger is driven with one-shot packets of lengths 5 and 130. It is also driven with a 300-byte packet that needs the staged high byte, and with cycle-mode runs of lengths 3, 1 and 0. Together these separate an off-by-one in the tag position, a missing reload or an unwanted one, and a high byte that is lost or takes effect too early. Overflow is driven with dropped writes placed inside a packet, so that a dropped byte that wrongly consumed count moves the tag. The low interrupt is stepped across two threshold codes, one byte at a time on each side of the boundary, so that a wrong code mapping or a strict compare shows up.

// File: rtl/txlen_pkg.sv
package txlen_pkg;
  typedef struct packed {
    logic       eop;
    logic [7:0] data;
  } txbyte_t;
endpackage

// File: rtl/txlen_counter.sv
module txlen_counter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cycle_en,
  input  logic              wr_acc,
  output logic              tag
);
  logic [BYTE_W-1:0] hi_stage;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  remain;

  // the byte written while one byte remains closes the packet
  assign tag = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage <= '0;
      len_q    <= '0;
      remain   <= '0;
    end else begin
      if (hi_we) hi_stage <= wdata;
      if (lo_we) begin
        len_q  <= {hi_stage, wdata};
        remain <= {hi_stage, wdata};
      end else if (wr_acc) begin
        if (tag)               remain <= cycle_en ? len_q : '0;
        else if (remain != '0) remain <= remain - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/txlen_fifo.sv
module txlen_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          full,
  output logic          accepted,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] wp, rp;

  assign level     = wp - rp;
  assign full      = (level == LW'(DEPTH));
  assign out_valid = (level != '0);
  assign accepted  = in_valid && !full;
  assign out_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (accepted) mem[wp[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (accepted)              wp <= wp + LW'(1);
      if (out_valid && out_ready) rp <= rp + LW'(1);
    end
  end
endmodule

// File: rtl/txlen_lowirq.sv
module txlen_lowirq #(
  parameter int LW    = 8,
  parameter int SEL_W = 3,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    level,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             irq
);
  logic [LW-1:0] thr;
  assign thr = LW'((int'(sel) + 1) * STEP);

  always_ff @(posedge clk) begin
    if (rst || clr) irq <= 1'b0;
    else if (level <= thr) irq <= 1'b1;
  end
endmodule

// File: rtl/txlen_tagger.sv
module txlen_tagger #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 128,
  parameter int SEL_W  = 3,
  parameter int STEP   = 8,
  localparam int OW    = BYTE_W + 1,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_hi_we,
  input  logic              cnt_lo_we,
  input  logic [BYTE_W-1:0] cnt_wdata,
  input  logic              cycle_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  low_sel,
  input  logic              low_clr,
  input  logic              ovf_clr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OW-1:0]     out_data,
  output logic              low_irq,
  output logic              ovf_flag
);
  logic          tag, full, accepted;
  logic [LW-1:0] level;

  txlen_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .hi_we(cnt_hi_we), .lo_we(cnt_lo_we),
    .wdata(cnt_wdata), .cycle_en(cycle_en), .wr_acc(accepted), .tag(tag)
  );

  txlen_fifo #(.W(OW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .in_valid(wr_en), .in_data({tag, wr_data}),
    .full(full), .accepted(accepted), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .level(level)
  );

  txlen_lowirq #(.LW(LW), .SEL_W(SEL_W), .STEP(STEP)) u_low (
    .clk(clk), .rst(rst), .level(level), .sel(low_sel),
    .clr(low_clr), .irq(low_irq)
  );

  always_ff @(posedge clk) begin
    if (rst || ovf_clr) ovf_flag <= 1'b0;
    else if (wr_en && full) ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/txlen_checker.sv
module txlen_checker #(
  parameter int OW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          low_clr,
  input logic          ovf_clr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          low_irq,
  input logic          ovf_flag
);
  // R1: reset leaves outputs quiet on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf_flag && !low_irq));

  // R7: a stalled output neither vanishes nor changes
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: overflow flag is sticky until cleared
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8: overflow only follows a write attempt
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(wr_en));

  // R8: clear strobe drops the flag
  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    ovf_clr |=> !ovf_flag);

  // R9: low interrupt is sticky until cleared
  a_r9_low_sticky: assert property (@(posedge clk) disable iff (rst)
    (low_irq && !low_clr) |=> low_irq);

  // R9: clear strobe forces the interrupt low
  a_r9_low_clear: assert property (@(posedge clk) disable iff (rst)
    low_clr |=> !low_irq);
endmodule

bind txlen_tagger txlen_checker #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .low_clr(low_clr), .ovf_clr(ovf_clr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .low_irq(low_irq), .ovf_flag(ovf_flag)
);

// File: tb/sim_txlen_tagger.sv
`timescale 1ns/1ps
module sim_txlen_tagger;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_hi_we = 0, cnt_lo_we = 0, cycle_en = 0, wr_en = 0;
  logic [7:0] cnt_wdata = 0, wr_data = 0;
  logic [2:0] low_sel = 0;
  logic       low_clr = 0, ovf_clr = 0, out_ready = 0;
  logic       out_valid, low_irq, ovf_flag;
  logic [8:0] out_data;

  int n_run = 0, n_fail = 0;
  logic [8:0] rxq [$];

  always #2.5 clk = ~clk;

  txlen_tagger u0 (
    .clk(clk), .rst(rst), .cnt_hi_we(cnt_hi_we), .cnt_lo_we(cnt_lo_we),
    .cnt_wdata(cnt_wdata), .cycle_en(cycle_en), .wr_en(wr_en),
    .wr_data(wr_data), .low_sel(low_sel), .low_clr(low_clr),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .low_irq(low_irq), .ovf_flag(ovf_flag)
  );

  always @(posedge clk)
    if (!rst && out_valid && out_ready) rxq.push_back(out_data);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_hi(input logic [7:0] v);
    @(negedge clk); cnt_hi_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_hi_we = 0;
  endtask

  task automatic wr_lo(input logic [7:0] v);
    @(negedge clk); cnt_lo_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_lo_we = 0;
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1; wr_data = 8'(base + i);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_low_clr();
    @(negedge clk); low_clr = 1;
    @(negedge clk); low_clr = 0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); out_ready = 1;
    end
    @(negedge clk); out_ready = 0;
  endtask

  task automatic drain();
    @(negedge clk); out_ready = 1;
    for (int i = 0; i < 400 && out_valid; i++) @(negedge clk);
    out_ready = 0;
    @(negedge clk);
  endtask

  // compare received bytes against the tag rule for length len
  task automatic verify(string req, int n, int base, int len, bit cyc);
    int bad = 0;
    check({req, " byte count"}, rxq.size(), n);
    for (int i = 0; i < rxq.size(); i++) begin
      bit t = (len > 0) && (cyc ? ((i + 1) % len == 0) : (i == len - 1));
      if (rxq[i] != {t, 8'(base + i)}) bad++;
    end
    check({req, " tag/data mismatches"}, bad, 0);
    rxq.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 ovf_flag in reset", ovf_flag, 0);
    check("R1 low_irq in reset", low_irq, 0);
    rst = 0;
  endtask

  task automatic t_single();
    wr_lo(8'd5);
    out_ready = 1;
    push(7, 8'h10);
    drain();
    verify("R3 R4 length 5", 7, 8'h10, 5, 0);
  endtask

  task automatic t_staging();
    wr_hi(8'h01);
    out_ready = 1;
    push(3, 8'h20);
    drain();
    verify("R2 staged high only", 3, 8'h20, 0, 0);
    wr_lo(8'h2C);
    out_ready = 1;
    push(300, 0);
    drain();
    verify("R10 length 300", 300, 0, 300, 0);
  endtask

  task automatic t_cycle();
    wr_hi(8'h00);
    cycle_en = 1;
    wr_lo(8'd3);
    out_ready = 1;
    push(9, 8'h30);
    drain();
    verify("R5 cycle length 3", 9, 8'h30, 3, 1);
    wr_lo(8'd1);
    out_ready = 1;
    push(4, 8'h50);
    drain();
    verify("R6 cycle length 1", 4, 8'h50, 1, 1);
    wr_lo(8'd0);
    out_ready = 1;
    push(3, 8'h60);
    drain();
    verify("R6 length 0", 3, 8'h60, 0, 1);
    cycle_en = 0;
  endtask

  task automatic t_stall();
    out_ready = 0;
    push(4, 8'h40);
    check("R7 valid when filled", out_valid, 1);
    check("R7 head data", out_data, 9'h040);
    repeat (3) @(negedge clk);
    check("R7 held under stall", out_data, 9'h040);
    drain();
    verify("R7 order", 4, 8'h40, 0, 0);
  endtask

  task automatic t_overflow_low();
    wr_lo(8'd130);
    out_ready = 0;
    low_sel = 3'd3;
    push(128, 0);
    check("R8 no overflow at exactly full", ovf_flag, 0);
    @(negedge clk); wr_en = 1; wr_data = 8'hEE;
    @(negedge clk); wr_data = 8'hEE;
    @(negedge clk); wr_en = 0;
    check("R8 overflow set", ovf_flag, 1);
    repeat (3) @(negedge clk);
    check("R8 overflow sticky", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    check("R8 overflow cleared", ovf_flag, 0);
    // threshold code 3 -> 32 bytes
    pulse_low_clr();
    check("R9 cleared", low_irq, 0);
    pop_n(95);
    @(negedge clk);
    check("R9 level 33 above 32", low_irq, 0);
    pop_n(1);
    @(negedge clk);
    check("R9 level 32 sets", low_irq, 1);
    // threshold code 1 -> 16 bytes
    low_sel = 3'd1;
    pulse_low_clr();
    @(negedge clk);
    check("R9 clear holds above 16", low_irq, 0);
    pop_n(15);
    @(negedge clk);
    check("R9 level 17 above 16", low_irq, 0);
    pop_n(1);
    @(negedge clk);
    check("R9 level 16 sets", low_irq, 1);
    push(2, 128);
    drain();
    verify("R8 dropped writes keep count", 130, 0, 130, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    t_single();
    t_staging();
    t_cycle();
    t_stall();
    t_overflow_low();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule